// File: doc/BRIEF.md
# Non-Blocking Prefetch Issue Queue

This block sits between one processor and a shared memory bus. It takes two kinds of traffic. Software prefetches are queued in order and sent later, so the processor keeps running while they are outstanding. Blocking demand loads stall the processor until their data is back. Before a prefetch enters the queue it is screened. A prefetch is discarded if the local cache already holds the line, in any state. It is also discarded if the same line is already waiting in the queue, already on the bus, or is the line of the pending demand load.

Prefetches that have been sent to the bus are tracked by line address in a small table. A demand load to one of those lines starts no new bus access. It attaches to the transfer already under way and completes when that transfer returns. When the block offers a request to the system arbiter, a waiting demand load always goes ahead of queued prefetches. Each prefetch can ask for its line either shared or exclusive. When a prefetch response comes back, its tracking entry is freed and the line is handed to the cache fill port in the same cycle.

Top module: `pf_issue_queue`

## Requirements
- R1: After reset, `bus_req`, `fill_valid` and `ld_done` are 0, and `pf_ready` and `ld_ready` are 1.
- R2: `pf_ready` is 0 exactly while DEPTH prefetches (16 by default) are queued. A prefetch presented while `pf_ready` is 0 is not taken and never reaches the bus.
- R3: A prefetch presented with `pf_cache_hit`=1 is discarded and never requests the bus.
- R4: A prefetch is discarded if its line matches a queued prefetch, an in-flight prefetch, or the line of an accepted demand load that has not completed.
- R5: While an accepted demand load has not yet been granted, `bus_req`=1 with `bus_pf`=0 and `bus_line` equal to the load's line, even if prefetches are queued.
- R6: Queued prefetches are offered to the bus in arrival order, with `bus_pf`=1. `bus_excl` repeats the prefetch's `pf_excl` bit (1 = exclusive read for an expected write, 0 = shared read).
- R7: At most NTRK prefetches (4 by default) are in flight. While all tracking entries are busy, no queued prefetch is offered.
- R8: A demand load whose line matches an in-flight prefetch makes no bus request. Its `ld_done` pulse comes in the same cycle as the `fill_valid` for that prefetch.
- R9: One cycle after a prefetch response (`bus_rsp_valid`=1, `bus_rsp_pf`=1), `fill_valid`=1 with that line and its exclusive flag. The tracking entry is free from that same cycle, so a queued prefetch can be offered in that cycle.
- R10: One cycle after the response to a demand load that went to the bus (`bus_rsp_pf`=0), `ld_done`=1 for one cycle and `ld_ready` returns to 1.
- R11: A demand load accepted in the same cycle as the response of the matching prefetch gives `ld_done`=1 in the next cycle, together with that line's `fill_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_valid | input | 1 | Prefetch request present |
| pf_line | input | LINE_W | Prefetch line address |
| pf_excl | input | 1 | 1 = exclusive prefetch, 0 = shared |
| pf_cache_hit | input | 1 | Local tag check hit for `pf_line` |
| pf_ready | output | 1 | Queue can take a prefetch |
| ld_valid | input | 1 | Demand load miss present |
| ld_line | input | LINE_W | Demand load line address |
| ld_ready | output | 1 | No demand load outstanding |
| ld_done | output | 1 | Demand load data returned (one cycle) |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_line | output | LINE_W | Requested line |
| bus_excl | output | 1 | Exclusive read request |
| bus_pf | output | 1 | Request is a prefetch (low priority) |
| bus_gnt | input | 1 | Arbiter grant for the current request |
| bus_rsp_valid | input | 1 | Bus transfer completed |
| bus_rsp_line | input | LINE_W | Line of the completed transfer |
| bus_rsp_pf | input | 1 | Completed transfer was a prefetch |
| fill_valid | output | 1 | Prefetched line ready for the cache fill |
| fill_line | output | LINE_W | Line to fill |
| fill_excl | output | 1 | Fill in exclusive state |

## Verification
Queue state changes at the clock edge that samples an input. The bus request therefore appears in the cycle after a prefetch or load is accepted, and the next request appears in the cycle after a grant. `fill_valid` and `ld_done` appear one cycle after the response that causes them. The bench drives each input on a falling edge and holds it for exactly one rising edge. It then reads the outputs on the following falling edge, which is the first point where those results are due. Negative cases, such as discarded prefetches or an absent bus request, are checked by draining the queue and watching `bus_req` and `bus_line`.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  // Demand load progress
  typedef enum logic [1:0] {
    DM_IDLE     = 2'd0,
    DM_WAIT_BUS = 2'd1,
    DM_ON_BUS   = 2'd2,
    DM_MERGED   = 2'd3
  } dm_state_e;
endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int DEPTH  = 16,
  parameter int LINE_W = 26,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [LINE_W-1:0] push_line,
  input  logic              push_excl,
  input  logic              pop,
  output logic              full,
  output logic              empty,
  output logic [LINE_W-1:0] head_line,
  output logic              head_excl,
  input  logic [LINE_W-1:0] chk_line,
  output logic              chk_hit
);
  logic [LINE_W-1:0] line_mem [DEPTH];
  logic              excl_mem [DEPTH];
  logic [DEPTH-1:0]  slot_vld;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       count;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == (AW+1)'(DEPTH));
  assign empty     = (count == '0);
  assign head_line = line_mem[rd_ptr];
  assign head_excl = excl_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      line_mem[wr_ptr] <= push_line;
      excl_mem[wr_ptr] <= push_excl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      slot_vld <= '0;
    end else begin
      if (push) begin
        wr_ptr           <= nxt(wr_ptr);
        slot_vld[wr_ptr] <= 1'b1;
      end
      if (pop) begin
        rd_ptr           <= nxt(rd_ptr);
        slot_vld[rd_ptr] <= 1'b0;
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    chk_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_vld[i] && (line_mem[i] == chk_line)) chk_hit = 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/pfq_tracker.sv
module pfq_tracker #(
  parameter int NTRK   = 4,
  parameter int LINE_W = 26,
  localparam int TW    = (NTRK > 1) ? $clog2(NTRK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic              alloc_excl,
  input  logic              rsp_valid,
  input  logic [LINE_W-1:0] rsp_line,
  input  logic [LINE_W-1:0] ld_line,
  input  logic [LINE_W-1:0] pf_line,
  output logic              avail,
  output logic              rsp_hit,
  output logic [TW-1:0]     rsp_idx,
  output logic              rsp_excl,
  output logic              ld_hit,
  output logic [TW-1:0]     ld_idx,
  output logic              pf_hit
);
  logic [NTRK-1:0]   ent_vld;
  logic [LINE_W-1:0] ent_line [NTRK];
  logic              ent_excl [NTRK];
  logic [TW-1:0]     alloc_idx;

  always_comb begin
    avail     = 1'b0;
    alloc_idx = '0;
    rsp_hit   = 1'b0;
    rsp_idx   = '0;
    ld_hit    = 1'b0;
    ld_idx    = '0;
    pf_hit    = 1'b0;
    for (int i = NTRK - 1; i >= 0; i--) begin
      if (!ent_vld[i]) begin
        avail     = 1'b1;
        alloc_idx = TW'(i);
      end
      if (ent_vld[i] && rsp_valid && (ent_line[i] == rsp_line)) begin
        rsp_hit = 1'b1;
        rsp_idx = TW'(i);
      end
      if (ent_vld[i] && (ent_line[i] == ld_line)) begin
        ld_hit = 1'b1;
        ld_idx = TW'(i);
      end
      if (ent_vld[i] && (ent_line[i] == pf_line)) pf_hit = 1'b1;
    end
    rsp_excl = ent_excl[rsp_idx];
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      ent_line[alloc_idx] <= alloc_line;
      ent_excl[alloc_idx] <= alloc_excl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
    end else begin
      if (alloc)   ent_vld[alloc_idx] <= 1'b1;
      if (rsp_hit) ent_vld[rsp_idx]   <= 1'b0;
    end
  end

  // R7
  trk_alloc_chk: assert property (@(posedge clk) disable iff (rst) alloc |-> avail);
  // R9
  trk_free_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |=> !ent_vld[$past(rsp_idx)]);
endmodule

// File: rtl/pfq_arb.sv
module pfq_arb #(
  parameter int LINE_W = 26
) (
  input  logic              dm_req,
  input  logic [LINE_W-1:0] dm_line,
  input  logic              pf_req,
  input  logic [LINE_W-1:0] pf_line,
  input  logic              pf_excl,
  output logic              req,
  output logic [LINE_W-1:0] line,
  output logic              excl,
  output logic              is_pf
);
  // Blocking loads always rank above prefetches
  always_comb begin
    req   = dm_req || pf_req;
    is_pf = !dm_req && pf_req;
    line  = dm_req ? dm_line : pf_line;
    excl  = dm_req ? 1'b0 : pf_excl;
  end
endmodule

// File: rtl/pf_issue_queue.sv
module pf_issue_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NTRK   = 4,
  parameter int LINE_W = 26,
  localparam int TW    = (NTRK > 1) ? $clog2(NTRK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pf_valid,
  input  logic [LINE_W-1:0] pf_line,
  input  logic              pf_excl,
  input  logic              pf_cache_hit,
  output logic              pf_ready,
  input  logic              ld_valid,
  input  logic [LINE_W-1:0] ld_line,
  output logic              ld_ready,
  output logic              ld_done,
  output logic              bus_req,
  output logic [LINE_W-1:0] bus_line,
  output logic              bus_excl,
  output logic              bus_pf,
  input  logic              bus_gnt,
  input  logic              bus_rsp_valid,
  input  logic [LINE_W-1:0] bus_rsp_line,
  input  logic              bus_rsp_pf,
  output logic              fill_valid,
  output logic [LINE_W-1:0] fill_line,
  output logic              fill_excl
);
  logic              q_full, q_empty, q_hit, q_push, q_pop;
  logic [LINE_W-1:0] head_line;
  logic              head_excl;
  logic              trk_avail, trk_rsp_hit, trk_rsp_excl, trk_ld_hit, trk_pf_hit;
  logic [TW-1:0]     trk_rsp_idx, trk_ld_idx;
  logic              arb_req, arb_excl, arb_is_pf;
  logic [LINE_W-1:0] arb_line;
  logic              rsp_is_pf, issue_pf, issue_dm, ld_acc, pf_dm_dup;

  dm_state_e         dm_st;
  logic [LINE_W-1:0] dm_line_q;
  logic [TW-1:0]     dm_idx_q;
  logic              ld_done_q, fill_vld_q, fill_excl_q;
  logic [LINE_W-1:0] fill_line_q;

  assign pf_dm_dup = (dm_st != DM_IDLE) && (dm_line_q == pf_line);
  assign q_push    = pf_valid && !q_full && !pf_cache_hit && !q_hit
                     && !trk_pf_hit && !pf_dm_dup;
  assign rsp_is_pf = bus_rsp_valid && bus_rsp_pf;
  assign issue_pf  = bus_gnt && arb_req && arb_is_pf;
  assign issue_dm  = bus_gnt && arb_req && !arb_is_pf;
  assign q_pop     = issue_pf;
  assign ld_acc    = ld_valid && (dm_st == DM_IDLE);

  pfq_fifo #(.DEPTH(DEPTH), .LINE_W(LINE_W)) fifo_i (
    .clk(clk), .rst(rst),
    .push(q_push), .push_line(pf_line), .push_excl(pf_excl),
    .pop(q_pop), .full(q_full), .empty(q_empty),
    .head_line(head_line), .head_excl(head_excl),
    .chk_line(pf_line), .chk_hit(q_hit)
  );

  pfq_tracker #(.NTRK(NTRK), .LINE_W(LINE_W)) trk_i (
    .clk(clk), .rst(rst),
    .alloc(issue_pf), .alloc_line(head_line), .alloc_excl(head_excl),
    .rsp_valid(rsp_is_pf), .rsp_line(bus_rsp_line),
    .ld_line(ld_line), .pf_line(pf_line),
    .avail(trk_avail), .rsp_hit(trk_rsp_hit), .rsp_idx(trk_rsp_idx),
    .rsp_excl(trk_rsp_excl), .ld_hit(trk_ld_hit), .ld_idx(trk_ld_idx),
    .pf_hit(trk_pf_hit)
  );

  pfq_arb #(.LINE_W(LINE_W)) arb_i (
    .dm_req(dm_st == DM_WAIT_BUS), .dm_line(dm_line_q),
    .pf_req(!q_empty && trk_avail), .pf_line(head_line), .pf_excl(head_excl),
    .req(arb_req), .line(arb_line), .excl(arb_excl), .is_pf(arb_is_pf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dm_st     <= DM_IDLE;
      dm_line_q <= '0;
      dm_idx_q  <= '0;
      ld_done_q <= 1'b0;
    end else begin
      ld_done_q <= 1'b0;
      case (dm_st)
        DM_IDLE: if (ld_acc) begin
          dm_line_q <= ld_line;
          dm_idx_q  <= trk_ld_idx;
          if (trk_ld_hit && trk_rsp_hit && (trk_rsp_idx == trk_ld_idx))
            ld_done_q <= 1'b1;
          else if (trk_ld_hit)
            dm_st <= DM_MERGED;
          else
            dm_st <= DM_WAIT_BUS;
        end
        DM_WAIT_BUS: if (issue_dm) dm_st <= DM_ON_BUS;
        DM_ON_BUS: if (bus_rsp_valid && !bus_rsp_pf) begin
          dm_st     <= DM_IDLE;
          ld_done_q <= 1'b1;
        end
        DM_MERGED: if (trk_rsp_hit && (trk_rsp_idx == dm_idx_q)) begin
          dm_st     <= DM_IDLE;
          ld_done_q <= 1'b1;
        end
        default: dm_st <= DM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_vld_q  <= 1'b0;
      fill_line_q <= '0;
      fill_excl_q <= 1'b0;
    end else begin
      fill_vld_q  <= trk_rsp_hit;
      fill_line_q <= bus_rsp_line;
      fill_excl_q <= trk_rsp_excl;
    end
  end

  assign pf_ready   = !q_full;
  assign ld_ready   = (dm_st == DM_IDLE);
  assign ld_done    = ld_done_q;
  assign bus_req    = arb_req;
  assign bus_line   = arb_line;
  assign bus_excl   = arb_excl;
  assign bus_pf     = arb_is_pf;
  assign fill_valid = fill_vld_q;
  assign fill_line  = fill_line_q;
  assign fill_excl  = fill_excl_q;

  // R5
  dm_first_chk: assert property (@(posedge clk) disable iff (rst)
    (dm_st == DM_WAIT_BUS) |-> (bus_req && !bus_pf && bus_line == dm_line_q));
  // R8
  merge_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (dm_st == DM_MERGED) |-> !(bus_req && !bus_pf));
  // R9
  fill_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_is_pf && trk_rsp_hit) |=> (fill_valid && fill_line == $past(bus_rsp_line)));
  // R10
  dm_done_chk: assert property (@(posedge clk) disable iff (rst)
    (dm_st == DM_ON_BUS && bus_rsp_valid && !bus_rsp_pf) |=> (ld_done && ld_ready));
endmodule

// File: tb/pf_issue_queue_tb.sv
`timescale 1ns/1ps
module pf_issue_queue_tb_top;
  localparam int LW = 26;
  // {keep[10], hit[9], excl[8], line[7:0]}
  localparam logic [10:0] TBL [0:7] = '{11'h410, 11'h511, 11'h010, 11'h212,
                                        11'h513, 11'h011, 11'h414, 11'h515};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pf_valid = 0, pf_excl = 0, pf_cache_hit = 0, ld_valid = 0;
  logic bus_gnt = 0, bus_rsp_valid = 0, bus_rsp_pf = 0;
  logic [LW-1:0] pf_line = '0, ld_line = '0, bus_rsp_line = '0;
  logic pf_ready, ld_ready, ld_done, bus_req, bus_excl, bus_pf;
  logic fill_valid, fill_excl;
  logic [LW-1:0] bus_line, fill_line;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pf_issue_queue dut_i (
    .clk(clk), .rst(rst), .pf_valid(pf_valid), .pf_line(pf_line),
    .pf_excl(pf_excl), .pf_cache_hit(pf_cache_hit), .pf_ready(pf_ready),
    .ld_valid(ld_valid), .ld_line(ld_line), .ld_ready(ld_ready),
    .ld_done(ld_done), .bus_req(bus_req), .bus_line(bus_line),
    .bus_excl(bus_excl), .bus_pf(bus_pf), .bus_gnt(bus_gnt),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_line(bus_rsp_line),
    .bus_rsp_pf(bus_rsp_pf), .fill_valid(fill_valid), .fill_line(fill_line),
    .fill_excl(fill_excl)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic push_pf(input logic [LW-1:0] ln, input logic ex, input logic hit);
    pf_valid = 1; pf_line = ln; pf_excl = ex; pf_cache_hit = hit;
    cyc();
    pf_valid = 0; pf_cache_hit = 0;
  endtask

  task automatic grant();
    bus_gnt = 1; cyc(); bus_gnt = 0;
  endtask

  task automatic respond(input logic [LW-1:0] ln, input logic is_pf);
    bus_rsp_valid = 1; bus_rsp_line = ln; bus_rsp_pf = is_pf;
    cyc();
    bus_rsp_valid = 0;
  endtask

  task automatic load(input logic [LW-1:0] ln);
    ld_valid = 1; ld_line = ln; cyc(); ld_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int issued;
    cyc(); cyc(); cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1 bus_req", bus_req, 0);
    chk("R1 fill_valid", fill_valid, 0);
    chk("R1 ld_done", ld_done, 0);
    chk("R1 pf_ready", pf_ready, 1);
    chk("R1 ld_ready", ld_ready, 1);

    // Table walk: R3, R4, R6, R7, R9
    for (int i = 0; i < 8; i++) push_pf(LW'(TBL[i][7:0]), TBL[i][8], TBL[i][9]);
    issued = 0;
    for (int i = 0; i < 8; i++) begin
      if (TBL[i][10]) begin
        if (issued == 4) begin
          chk("R7 trackers full", bus_req, 0);
          respond(LW'(TBL[0][7:0]), 1);
          chk("R9 fill_valid", fill_valid, 1);
          chk("R9 fill_line", fill_line, TBL[0][7:0]);
          chk("R9 fill_excl", fill_excl, TBL[0][8]);
          chk("R9 freed entry reused", bus_req, 1);
        end
        chk("R6 bus_req", bus_req, 1);
        chk("R6 bus_pf", bus_pf, 1);
        chk("R6 order", bus_line, TBL[i][7:0]);
        chk("R6 excl", bus_excl, TBL[i][8]);
        grant();
        issued++;
      end
    end
    chk("R3 R4 dropped never issued", bus_req, 0);
    for (int i = 1; i < 8; i++) begin
      if (TBL[i][10]) begin
        respond(LW'(TBL[i][7:0]), 1);
        chk("R9 fill line", fill_line, TBL[i][7:0]);
        chk("R9 fill excl", fill_excl, TBL[i][8]);
      end
    end
    cyc();
    chk("R9 fill clears", fill_valid, 0);

    // R5 demand first, R4 vs pending demand, R10
    push_pf(LW'('h20), 0, 0);
    load(LW'('h30));
    chk("R5 demand first req", bus_req, 1);
    chk("R5 demand first pf", bus_pf, 0);
    chk("R5 demand line", bus_line, 'h30);
    chk("R5 ld_ready busy", ld_ready, 0);
    push_pf(LW'('h30), 0, 0);
    grant();
    chk("R5 prefetch after demand", bus_line, 'h20);
    chk("R5 prefetch flag", bus_pf, 1);
    grant();
    chk("R4 demand line dup dropped", bus_req, 0);
    respond(LW'('h30), 0);
    chk("R10 ld_done", ld_done, 1);
    chk("R10 ld_ready", ld_ready, 1);
    cyc();
    chk("R10 ld_done pulse", ld_done, 0);

    // R4 vs in-flight, R8 merge
    push_pf(LW'('h20), 1, 0);
    chk("R4 in-flight dup dropped", bus_req, 0);
    load(LW'('h20));
    chk("R8 no bus req", bus_req, 0);
    chk("R8 ld_ready busy", ld_ready, 0);
    cyc(); cyc();
    chk("R8 waits", ld_done, 0);
    respond(LW'('h20), 1);
    chk("R8 ld_done", ld_done, 1);
    chk("R8 fill same cycle", fill_valid, 1);
    chk("R8 fill line", fill_line, 'h20);

    // R11 demand lands with the response
    push_pf(LW'('h40), 1, 0);
    grant();
    ld_valid = 1; ld_line = LW'('h40);
    bus_rsp_valid = 1; bus_rsp_line = LW'('h40); bus_rsp_pf = 1;
    cyc();
    ld_valid = 0; bus_rsp_valid = 0;
    chk("R11 ld_done", ld_done, 1);
    chk("R11 fill", fill_valid, 1);
    chk("R11 fill excl", fill_excl, 1);
    chk("R11 ld_ready", ld_ready, 1);
    cyc();
    chk("R11 no bus req", bus_req, 0);
    chk("R11 ld_done pulse", ld_done, 0);

    // R2 full queue
    for (int i = 0; i < 16; i++) begin
      chk("R2 ready before full", pf_ready, 1);
      push_pf(LW'('h100 + i), 0, 0);
    end
    chk("R2 full", pf_ready, 0);
    push_pf(LW'('h200), 0, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R2 drain order", bus_line, 'h100 + i);
      grant();
      if (i == 0) chk("R2 ready after pop", pf_ready, 1);
      respond(LW'('h100 + i), 1);
    end
    chk("R2 rejected never issued", bus_req, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule